// File: doc/BRIEF.md
# Readout Controller Flow-Control Front

This block sits at the edge of one readout controller in a layered, event-driven acquisition chain. It produces the controller's Busy line by merging a local Busy input, the Busy lines coming from the stages below, and an almost-full flag. That flag is derived from the occupancy of the controller's own output FIFO and a programmable threshold.

The block also keeps an event number, advancing it once per trigger. When a synchronization request arrives, it checks the low part of that number against an expected value loaded by configuration. A mismatch raises a sync-failure line and a halt line. Both are sticky, because the condition cannot be recovered from without outside action.

Trigger, sync request, Busy, halt and sync failure make up the five-line bus to the supervisor. The FIFO storage itself and the data path are outside this block.

Top module: `daq_flow_ctrl`

## Requirements
- R1: `busyOut` is high in the same cycle whenever `localBusyIn` is high, any bit of `downBusyIn` is high, or the almost-full flag is set; otherwise it is low.
- R2: The almost-full flag is set when `fifoLevelIn` is greater than or equal to the threshold register. The threshold resets to DEF_THR (default 48) and is written from `cfgWrData[LVL_W-1:0]` by a write with `cfgSel` = 0.
- R3: `eventNumOut` resets to 0 and increases by one after every rising clock edge at which `trigIn` is high.
- R4: At a rising edge with `syncReqIn` high, the low CMP_W (16) bits of the event number are compared with the expected register. The event number used is the value before that edge's own increment. The expected register is written by `cfgSel` = 1 and resets to 0. On a mismatch, `syncFailOut` and `haltOut` are both high from the next cycle on.
- R5: A sync check that matches leaves `syncFailOut` and `haltOut` unchanged.
- R6: Once set, `syncFailOut` and `haltOut` stay high until reset or a write with `cfgSel` = 2. If a failing check falls on the same edge as such a write, the flags stay set.
- R7: After reset, `busyOut` follows only its inputs, and `haltOut`, `syncFailOut` and `eventNumOut` are 0.
- R8: A configuration cycle with `cfgWrEn` low, or with `cfgSel` = 3, changes neither the threshold, the expected register nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Trigger pulse, counted once per high cycle |
| syncReqIn | input | 1 | Synchronization request |
| localBusyIn | input | 1 | Busy from the local source |
| downBusyIn | input | NUM_DOWN | Busy lines from the stages below |
| fifoLevelIn | input | LVL_W | Occupancy of this controller's output FIFO |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgSel | input | 2 | Register select: 0 threshold, 1 expected count, 2 clear flags |
| cfgWrData | input | CMP_W | Configuration write data |
| busyOut | output | 1 | Merged Busy |
| haltOut | output | 1 | Sticky unrecoverable-error line |
| syncFailOut | output | 1 | Sticky synchronization-failure line |
| eventNumOut | output | EVT_W | Current event number |

## Verification
The Busy merge is driven by each source in isolation. This shows that every input reaches the output, and that no single one gates the others. The FIFO level is set at the threshold, at one below it, and at the largest value, both before and after the threshold is rewritten; this separates a ">=" comparison from a ">" one. Sync requests are given with the expected value equal to the count, with a wrong value, and on the same edge as a trigger. The last case shows whether the comparison uses the count before or after its increment. Clear writes alone, together with a failing check, and with the enable low show stickiness and set priority. A long random mix of triggers, sync requests, level changes and writes then checks everything against a bench-side model.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam logic [1:0] SEL_THR = 2'd0;
  localparam logic [1:0] SEL_EXP = 2'd1;
  localparam logic [1:0] SEL_CLR = 2'd2;

  typedef struct packed {
    logic cntInc;
    logic syncChk;
    logic wrThr;
    logic wrExp;
    logic clrFlags;
  } fc_strobe_t;
endpackage

// File: rtl/fc_ctrl.sv
module fc_ctrl
  import fc_pkg::*;
#(
  parameter int NUM_DOWN = 4
) (
  input  logic                trigIn,
  input  logic                syncReqIn,
  input  logic                cfgWrEn,
  input  logic [1:0]          cfgSel,
  input  logic                localBusyIn,
  input  logic [NUM_DOWN-1:0] downBusyIn,
  input  logic                afFlag,
  output fc_strobe_t          stb,
  output logic                busyOut
);
  logic downAny;

  always_comb begin
    downAny = 1'b0;
    for (int i = 0; i < NUM_DOWN; i++) downAny = downAny | downBusyIn[i];
  end

  always_comb begin
    stb          = '0;
    stb.cntInc   = trigIn;
    stb.syncChk  = syncReqIn;
    stb.wrThr    = cfgWrEn && (cfgSel == SEL_THR);
    stb.wrExp    = cfgWrEn && (cfgSel == SEL_EXP);
    stb.clrFlags = cfgWrEn && (cfgSel == SEL_CLR);
  end

  assign busyOut = localBusyIn | downAny | afFlag;
endmodule

// File: rtl/fc_datapath.sv
module fc_datapath
  import fc_pkg::*;
#(
  parameter int EVT_W   = 24,
  parameter int CMP_W   = 16,
  parameter int LVL_W   = 6,
  parameter int DEF_THR = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  fc_strobe_t       stb,
  input  logic [CMP_W-1:0] wrData,
  input  logic [LVL_W-1:0] fifoLevel,
  output logic             afFlag,
  output logic [EVT_W-1:0] eventNum,
  output logic             syncFail,
  output logic             halt
);
  localparam logic [LVL_W-1:0] THR_RST = LVL_W'(DEF_THR);

  logic [LVL_W-1:0] thrQ;
  logic [CMP_W-1:0] expQ;
  logic [EVT_W-1:0] evtQ;
  logic             failQ, haltQ;
  logic             mismatch;

  assign mismatch = stb.syncChk && (evtQ[CMP_W-1:0] != expQ);
  assign afFlag   = (fifoLevel >= thrQ);
  assign eventNum = evtQ;
  assign syncFail = failQ;
  assign halt     = haltQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrQ <= THR_RST;
      expQ <= '0;
    end else begin
      if (stb.wrThr) thrQ <= wrData[LVL_W-1:0];
      if (stb.wrExp) expQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           evtQ <= '0;
    else if (stb.cntInc) evtQ <= evtQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      failQ <= 1'b0;
      haltQ <= 1'b0;
    end else if (mismatch) begin
      failQ <= 1'b1;
      haltQ <= 1'b1;
    end else if (stb.clrFlags) begin
      failQ <= 1'b0;
      haltQ <= 1'b0;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntInc |=> eventNum == $past(eventNum) + 1'b1); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cntInc |=> $stable(eventNum)); // R3
  AST_FAIL_SET: assert property (@(posedge clk) disable iff (!rstN)
    (stb.syncChk && eventNum[CMP_W-1:0] != expQ) |=> (syncFail && halt)); // R4
  AST_MATCH_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.syncChk && eventNum[CMP_W-1:0] == expQ && !stb.clrFlags) |=> $stable(syncFail)); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (syncFail && !stb.clrFlags) |=> syncFail); // R6
  AST_HALT_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    syncFail == halt); // R4
endmodule

// File: rtl/daq_flow_ctrl.sv
module daq_flow_ctrl
  import fc_pkg::*;
#(
  parameter int NUM_DOWN = 4,
  parameter int EVT_W    = 24,
  parameter int CMP_W    = 16,
  parameter int LVL_W    = 6,
  parameter int DEF_THR  = 48
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                trigIn,
  input  logic                syncReqIn,
  input  logic                localBusyIn,
  input  logic [NUM_DOWN-1:0] downBusyIn,
  input  logic [LVL_W-1:0]    fifoLevelIn,
  input  logic                cfgWrEn,
  input  logic [1:0]          cfgSel,
  input  logic [CMP_W-1:0]    cfgWrData,
  output logic                busyOut,
  output logic                haltOut,
  output logic                syncFailOut,
  output logic [EVT_W-1:0]    eventNumOut
);
  fc_strobe_t stb;
  logic       afFlag;

  fc_ctrl #(.NUM_DOWN(NUM_DOWN)) u_ctrl (
    .trigIn(trigIn), .syncReqIn(syncReqIn), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .localBusyIn(localBusyIn), .downBusyIn(downBusyIn), .afFlag(afFlag),
    .stb(stb), .busyOut(busyOut)
  );

  fc_datapath #(.EVT_W(EVT_W), .CMP_W(CMP_W), .LVL_W(LVL_W), .DEF_THR(DEF_THR)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(cfgWrData), .fifoLevel(fifoLevelIn),
    .afFlag(afFlag), .eventNum(eventNumOut), .syncFail(syncFailOut), .halt(haltOut)
  );

  AST_AF_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    afFlag |-> busyOut); // R1
  AST_SRC_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (localBusyIn || (|downBusyIn)) |-> busyOut); // R1
  AST_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!localBusyIn && !(|downBusyIn) && !afFlag) |-> !busyOut); // R1
endmodule

// File: tb/daq_flow_ctrl_bench.sv
module daq_flow_ctrl_bench;
  localparam int ND = 4, EW = 24, CW = 16, LW = 6, DT = 48;

  logic clk = 1'b0, rstN = 1'b0;
  logic trigIn = 0, syncReqIn = 0, localBusyIn = 0, cfgWrEn = 0;
  logic [ND-1:0] downBusyIn = '0;
  logic [LW-1:0] fifoLevelIn = '0;
  logic [1:0] cfgSel = '0;
  logic [CW-1:0] cfgWrData = '0;
  logic busyOut, haltOut, syncFailOut;
  logic [EW-1:0] eventNumOut;

  int nChk = 0, nBad = 0;
  logic done = 1'b0;

  logic [EW-1:0] mCnt;
  logic [LW-1:0] mThr;
  logic [CW-1:0] mExp;
  logic mFail;

  always #2.5 clk = ~clk;

  daq_flow_ctrl u_daq_flow_ctrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .syncReqIn(syncReqIn),
    .localBusyIn(localBusyIn), .downBusyIn(downBusyIn), .fifoLevelIn(fifoLevelIn),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .busyOut(busyOut), .haltOut(haltOut), .syncFailOut(syncFailOut), .eventNumOut(eventNumOut)
  );

  function automatic logic expBusy();
    return localBusyIn | (|downBusyIn) | (fifoLevelIn >= mThr);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // Called just after a falling edge with inputs applied.
  task automatic cycle();
    logic nf;
    #1 chk("R1/R2 busy", {31'd0, busyOut}, {31'd0, expBusy()});
    @(posedge clk);
    nf = mFail;
    if (cfgWrEn && cfgSel == 2'd2) nf = 1'b0;
    if (syncReqIn && mCnt[CW-1:0] != mExp) nf = 1'b1;
    if (cfgWrEn && cfgSel == 2'd0) mThr = cfgWrData[LW-1:0];
    if (cfgWrEn && cfgSel == 2'd1) mExp = cfgWrData;
    if (trigIn) mCnt = mCnt + 1'b1;
    mFail = nf;
    @(negedge clk);
    chk("R3 count", 32'(eventNumOut), 32'(mCnt));
    chk("R4/R5/R6 syncFail", {31'd0, syncFailOut}, {31'd0, mFail});
    chk("R4 halt", {31'd0, haltOut}, {31'd0, mFail});
  endtask

  task automatic idle();
    trigIn = 0; syncReqIn = 0; cfgWrEn = 0; cfgSel = 0; cfgWrData = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [CW-1:0] d);
    idle(); cfgWrEn = 1; cfgSel = s; cfgWrData = d; cycle(); idle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    mCnt = '0; mThr = LW'(DT); mExp = '0; mFail = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R7 reset state
    chk("R7 halt", {31'd0, haltOut}, 32'd0);
    chk("R7 syncFail", {31'd0, syncFailOut}, 32'd0);
    chk("R7 count", 32'(eventNumOut), 32'd0);
    chk("R7 busy idle", {31'd0, busyOut}, 32'd0);
    @(negedge clk);

    // R1 each source alone
    localBusyIn = 1; cycle(); localBusyIn = 0;
    for (int i = 0; i < ND; i++) begin downBusyIn = '0; downBusyIn[i] = 1; cycle(); end
    downBusyIn = '0; cycle();

    // R2 threshold boundaries, default and rewritten
    fifoLevelIn = LW'(DT - 1); cycle();
    fifoLevelIn = LW'(DT); cycle();
    wr(2'd0, 16'd10);
    fifoLevelIn = 6'd9; cycle();
    fifoLevelIn = 6'd10; cycle();
    fifoLevelIn = 6'd63; cycle();
    fifoLevelIn = 6'd0; cycle();

    // R8 ignored writes: enable low, select 3
    idle(); cfgSel = 2'd0; cfgWrData = 16'd2; cycle(); idle();
    fifoLevelIn = 6'd5; cycle();   // R8: threshold still 10 -> not busy
    wr(2'd3, 16'd1); cycle();
    fifoLevelIn = 6'd0;

    // R3 triggers
    for (int i = 0; i < 5; i++) begin trigIn = 1; cycle(); end
    idle(); cycle();

    // R5 matching sync
    wr(2'd1, mCnt[CW-1:0]);
    syncReqIn = 1; cycle(); idle();
    // R4 sync with trigger on same edge: compares pre-increment value
    syncReqIn = 1; trigIn = 1; cycle(); idle();
    // R4 mismatch now (count moved on)
    syncReqIn = 1; cycle(); idle();
    // R6 sticky across idle and a matching check
    cycle();
    wr(2'd1, mCnt[CW-1:0]);
    syncReqIn = 1; cycle(); idle();
    // R8 select 3 does not clear
    wr(2'd3, 16'd0);
    // R6 clear
    wr(2'd2, 16'd0);
    // R6 clear together with failing check: set wins
    wr(2'd1, 16'hBEEF);
    idle(); cfgWrEn = 1; cfgSel = 2'd2; syncReqIn = 1; cycle(); idle();
    wr(2'd2, 16'd0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      idle();
      trigIn      = ($urandom % 3) == 0;
      syncReqIn   = ($urandom % 10) == 0;
      localBusyIn = ($urandom % 4) == 0;
      downBusyIn  = (($urandom % 3) == 0) ? ND'($urandom) : '0;
      fifoLevelIn = LW'($urandom);
      if (($urandom % 6) == 0) begin
        cfgWrEn = 1;
        cfgSel  = 2'($urandom);
        case (cfgSel)
          2'd0: cfgWrData = CW'($urandom % 64);
          2'd1: cfgWrData = (($urandom % 4) == 0) ? CW'($urandom) : mCnt[CW-1:0];
          default: cfgWrData = CW'($urandom);
        endcase
      end
      cycle();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule